// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Counter

This block turns a two-ratio prescaler (dividing by P or P+1) into a divider with a programmable overall ratio. Each output pulse of the prescaler reaches the block as a one-cycle enable, `pulse_en`, on the system clock. The block groups these pulses into count cycles of `m_in` pulses each. For the first `a_in` pulses of a count cycle it holds `mod_ctl` low, which selects the P+1 ratio. For the remaining pulses it drives `mod_ctl` high, which selects P. One count cycle therefore spans `m_in`·P + `a_in` prescaler input periods.

At the end of each count cycle the block emits a one-clock strobe, `fv`, and both counts restart together. The swallow value and the main value are taken from the inputs when the first pulse of a count cycle arrives. Changes made while a cycle is running wait for the next cycle. A registered flag, `cfg_err`, reports a programmed main value that is below 8 or below the swallow value.

Top module: `swallow_counter`

## Requirements
- R1: While `rst_n` is low, `fv` and `cfg_err` are 0, and the block sits at the start of a count cycle with no pulses counted.
- R2: Number the pulses of a count cycle k = 0, 1, 2, and so on, where k is the count of pulses already taken in that cycle. Once k is 1 or more, `mod_ctl` is 0 while k < A and 1 while k >= A. Here A is the swallow value held for that cycle.
- R3: With A = 0, `mod_ctl` is 1 from the start of the count cycle, through every pulse, to the end of the cycle.
- R4: The clock edge that samples the M-th pulse of a count cycle ends that cycle. `fv` is 1 for exactly the one clock after that edge, and the counts restart at k = 0.
- R5: Each count cycle holds exactly M pulses, for every legal M from 8 to 1023 and every A from 0 to 127 with A <= M.
- R6: While k = 0, `mod_ctl` follows the live `a_in` (1 when `a_in` = 0). The first pulse of a cycle captures `a_in` and `m_in` for that whole cycle. Changes to `a_in` or `m_in` at k >= 1 have no effect until the next cycle.
- R7: `cfg_err` is 1 in the clock after `m_in` < 8 or `m_in` < `a_in`, and 0 in the clock after a legal pair.
- R8: A clock with `pulse_en` low does not advance the count, and `fv` is 0 in the clock after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_en | input | 1 | One-cycle enable for each prescaler output pulse |
| a_in | input | 7 | Programmed swallow value A |
| m_in | input | 10 | Programmed main value M |
| mod_ctl | output | 1 | Prescaler ratio select: 0 selects P+1, 1 selects P |
| fv | output | 1 | One-clock strobe at the end of each count cycle |
| cfg_err | output | 1 | Registered flag for an illegal pair of programmed values |

## Verification
`fv` and `cfg_err` are registered, so each is due one clock after the edge that samples its cause. `mod_ctl` is decoded from the count, so it settles right after that same edge. When k = 0 it also follows `a_in` with no register in the path. The scoreboard monitor records whether a pulse was present at each rising edge and compares its queued expectation a quarter period later, so every value is read after that edge has taken effect. The direct checks on `cfg_err` wait for two falling edges after a change, and the checks on `mod_ctl` at k = 0 read it one time unit after `a_in` is driven.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
    localparam int unsigned SW_A_W   = 7;
    localparam int unsigned SW_M_W   = 10;
    localparam int unsigned SW_M_MIN = 8;
endpackage

// File: rtl/swallow_cfg_check.sv
module swallow_cfg_check #(
    parameter int unsigned A_W   = swallow_pkg::SW_A_W,
    parameter int unsigned M_W   = swallow_pkg::SW_M_W,
    parameter int unsigned M_MIN = swallow_pkg::SW_M_MIN
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] a_in,
    input  logic [M_W-1:0] m_in,
    output logic           err_o
);
    localparam int unsigned PAD = M_W - A_W;

    logic err_d, err_q;

    always_comb begin
        err_d = (m_in < M_W'(M_MIN)) || (m_in < {{PAD{1'b0}}, a_in});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign err_o = err_q;
endmodule

// File: rtl/swallow_mc_decode.sv
module swallow_mc_decode #(
    parameter int unsigned A_W = swallow_pkg::SW_A_W,
    parameter int unsigned M_W = swallow_pkg::SW_M_W
) (
    input  logic [M_W-1:0] cnt_i,
    input  logic [A_W-1:0] a_live_i,
    input  logic [A_W-1:0] a_held_i,
    output logic           mc_o
);
    localparam int unsigned PAD = M_W - A_W;

    always_comb begin
        if (cnt_i == '0) mc_o = (a_live_i == '0);
        else             mc_o = (cnt_i >= {{PAD{1'b0}}, a_held_i});
    end
endmodule

// File: rtl/swallow_counter.sv
module swallow_counter #(
    parameter int unsigned A_W   = swallow_pkg::SW_A_W,
    parameter int unsigned M_W   = swallow_pkg::SW_M_W,
    parameter int unsigned M_MIN = swallow_pkg::SW_M_MIN
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pulse_en,
    input  logic [A_W-1:0] a_in,
    input  logic [M_W-1:0] m_in,
    output logic           mod_ctl,
    output logic           fv,
    output logic           cfg_err
);
    typedef struct packed {
        logic [M_W-1:0] cnt;
        logic [A_W-1:0] a;
        logic [M_W-1:0] m;
        logic           fv;
    } state_t;

    state_t         st_d, st_q;
    logic           at_start;
    logic [M_W-1:0] m_eff;

    always_comb begin
        st_d     = st_q;
        st_d.fv  = 1'b0;
        at_start = (st_q.cnt == '0);
        m_eff    = at_start ? m_in : st_q.m;
        if (pulse_en) begin
            if (at_start) begin
                st_d.a = a_in;
                st_d.m = m_in;
            end
            if (st_q.cnt == m_eff - M_W'(1)) begin
                st_d.cnt = '0;
                st_d.fv  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + M_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    swallow_mc_decode #(.A_W(A_W), .M_W(M_W)) u_mc (
        .cnt_i    (st_q.cnt),
        .a_live_i (a_in),
        .a_held_i (st_q.a),
        .mc_o     (mod_ctl)
    );

    swallow_cfg_check #(.A_W(A_W), .M_W(M_W), .M_MIN(M_MIN)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .a_in  (a_in),
        .m_in  (m_in),
        .err_o (cfg_err)
    );

    assign fv = st_q.fv;
endmodule

// File: rtl/swallow_counter_chk.sv
module swallow_counter_chk #(
    parameter int unsigned A_W   = swallow_pkg::SW_A_W,
    parameter int unsigned M_W   = swallow_pkg::SW_M_W,
    parameter int unsigned M_MIN = swallow_pkg::SW_M_MIN
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pulse_en,
    input logic [A_W-1:0] a_in,
    input logic [M_W-1:0] m_in,
    input logic           mod_ctl,
    input logic           fv,
    input logic           cfg_err
);
    localparam int unsigned PAD = M_W - A_W;

    // R4: with a legal main value, two strobes never come back to back
    assert_fv_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fv && ($past(m_in) >= M_W'(M_MIN))) |-> !$past(fv));

    // R8: no pulse, no strobe in the next clock
    assert_idle_no_fv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_en |=> !fv);

    // R2 / R3: a new cycle opens with mod_ctl low unless A is 0
    assert_cycle_open_mc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fv |-> (mod_ctl == (a_in == '0)));

    // R7: a main value below the minimum raises the flag
    assert_err_low_m_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_in < M_W'(M_MIN)) |=> cfg_err);

    // R7: a legal pair clears the flag
    assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_in >= M_W'(M_MIN)) && (m_in >= {{PAD{1'b0}}, a_in})) |=> !cfg_err);

    // R1: outputs held low during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!fv && !cfg_err);
        end
    end
endmodule

bind swallow_counter swallow_counter_chk #(.A_W(A_W), .M_W(M_W), .M_MIN(M_MIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse_en (pulse_en),
    .a_in     (a_in),
    .m_in     (m_in),
    .mod_ctl  (mod_ctl),
    .fv       (fv),
    .cfg_err  (cfg_err)
);

// File: tb/swallow_counter_test.sv
module swallow_counter_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pulse_en = 1'b0;
    logic [6:0] a_in = 7'd3;
    logic [9:0] m_in = 10'd10;
    logic       mod_ctl, fv, cfg_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        bit    fv;
        bit    mc;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    // reference model of the count-cycle behaviour
    int mdl_cnt = 0;
    int mdl_a = 0;
    int mdl_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swallow_counter uut (
        .clk(clk), .rst_n(rst_n), .pulse_en(pulse_en),
        .a_in(a_in), .m_in(m_in),
        .mod_ctl(mod_ctl), .fv(fv), .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_pulse(input string tag, input int gap);
        exp_t e;
        @(negedge clk);
        if (mdl_cnt == 0) begin
            mdl_a = int'(a_in);
            mdl_m = int'(m_in);
        end
        e.tag = tag;
        if (mdl_cnt == mdl_m - 1) begin
            mdl_cnt = 0;
            e.fv = 1;
            e.mc = (a_in == 0);
        end else begin
            mdl_cnt++;
            e.fv = 0;
            e.mc = (mdl_cnt >= mdl_a);
        end
        sb_q.push_back(e);
        pulse_en = 1'b1;
        @(negedge clk);
        pulse_en = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic run_cycle(input int a, input int m, input string tag, input int gap);
        @(negedge clk);
        a_in = 7'(a);
        m_in = 10'(m);
        for (int i = 0; i < m; i++) do_pulse(tag, (i % 3 == 0) ? gap : 0);
    endtask

    // monitor: pops one expectation per sampled pulse
    initial begin
        forever begin
            bit had;
            @(posedge clk);
            had = pulse_en && rst_n;
            #(CLK_PERIOD/4);
            if (had) begin
                exp_t e;
                if (sb_q.size() == 0) begin
                    check("R4 scoreboard empty", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    check({e.tag, " fv"}, int'(fv), int'(e.fv));
                    check({e.tag, " mod_ctl"}, int'(mod_ctl), int'(e.mc));
                end
            end else if (rst_n) begin
                check("R8 fv after idle clock", int'(fv), 0);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 fv in reset", int'(fv), 0);
        check("R1 cfg_err in reset", int'(cfg_err), 0);
        check("R1 mod_ctl at cycle start", int'(mod_ctl), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_cycle(3, 10, "R2", 2);
        run_cycle(3, 10, "R5", 0);
        run_cycle(0, 8, "R3", 1);
        run_cycle(9, 9, "R5 A=M", 0);
        run_cycle(127, 1023, "R5 max", 0);

        // R6: live a_in drives mod_ctl at k=0
        @(negedge clk);
        a_in = 7'd0;
        #1 check("R6 mod_ctl follows a_in=0 at k=0", int'(mod_ctl), 1);
        a_in = 7'd4;
        #1 check("R6 mod_ctl follows a_in=4 at k=0", int'(mod_ctl), 0);

        // R6: mid-cycle change ignored until next cycle
        a_in = 7'd2;
        m_in = 10'd8;
        for (int i = 0; i < 3; i++) do_pulse("R6 start", 1);
        @(negedge clk);
        a_in = 7'd5;
        m_in = 10'd12;
        for (int i = 0; i < 5; i++) do_pulse("R6 held", 0);
        for (int i = 0; i < 12; i++) do_pulse("R6 next", 1);

        // R7: configuration flag
        @(negedge clk);
        m_in = 10'd5; a_in = 7'd0;
        repeat (2) @(negedge clk);
        check("R7 m below minimum", int'(cfg_err), 1);
        m_in = 10'd20; a_in = 7'd30;
        repeat (2) @(negedge clk);
        check("R7 m below a", int'(cfg_err), 1);
        m_in = 10'd20; a_in = 7'd20;
        repeat (2) @(negedge clk);
        check("R7 legal m equal a", int'(cfg_err), 0);

        repeat (4) @(negedge clk);
        check("R4 scoreboard drained", sb_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule